// File: doc/BRIEF.md
# Seconds Score Timer Display

This block keeps the running play time of a game in whole seconds and presents it on a four-position, common-anode seven-segment display that is scanned one position at a time. While the count-enable input is high, an internal divider produces a single-cycle pulse once per second, and a chain of four BCD counters (ones, tens, hundreds, thousands) advances on that pulse. When the enable drops, both the count and the partial progress toward the next second are frozen.

A second, independent divider produces the scan pulse that steps the active display position. For each position the block drives one active-low anode and the active-low segment pattern of that position's digit. Both dividers are clock enables in the single system clock domain. No derived clocks are used.

Top module: `score_timer_display`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears all four digits, the seconds divider and the scan position. After reset the display shows position 0 with digit value 0.
- R2: While `count_en` is high, the count rises by exactly one at every TICK_DIV-th enabled rising edge. While `count_en` is low, the count and the seconds divider's partial progress do not change, so enabled cycles split across pauses add up.
- R3: Each BCD digit steps from 9 back to 0 and carries one into the next-higher digit (for example 9 becomes 10, 99 becomes 100, 999 becomes 1000).
- R4: At 9999 the count saturates. Further enabled seconds leave it at 9999.
- R5: Exactly one anode is low at a time. `an_n[0]` selects the ones digit, `an_n[1]` the tens, `an_n[2]` the hundreds and `an_n[3]` the thousands. The scan visits them in ascending order and wraps from 3 to 0. It holds each position for REFRESH_DIV cycles, whatever the state of `count_en`.
- R6: `seg_n[6:0]` is active low with bit 0 = segment a through bit 6 = segment g. Digits 0..9 appear as hex 40, 79, 24, 30, 19, 12, 02, 78, 00, 10. `dp_n` is always 1.
- R7: The pattern driven while position k is selected is the encoding of decimal digit k of the current count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| count_en | input | 1 | High while a game is running; gates the seconds count |
| an_n | output | DIGITS | Active-low position selects, bit k = decimal digit k |
| seg_n | output | 7 | Active-low segments, bit 0 = a ... bit 6 = g |
| dp_n | output | 1 | Active-low decimal point, held off (1) |

## Verification
A count change lands on the TICK_DIV-th enabled rising edge. The anode and segment outputs are decoded combinationally from registers, so the new value is visible in the same cycle after that edge. A scan step likewise appears right after every REFRESH_DIV-th edge. The bench drives inputs and samples outputs on falling edges, so each driver task holds `count_en` high for a whole number of TICK_DIV-cycle seconds and then lowers it. The monitor then reads the stable value by watching one full scan. Scan timing is checked by counting falling edges between anode changes, which must equal REFRESH_DIV.

// File: rtl/score_disp_pkg.sv
package score_disp_pkg;

  localparam int unsigned SEG_W = 7;

  typedef logic [3:0] bcd_t;

  // True when a BCD digit holds its largest value.
  function automatic logic is_nine(input bcd_t d);
    return d == 4'd9;
  endfunction

  // Next BCD digit value on an increment, wrapping 9 -> 0.
  function automatic bcd_t bcd_step(input bcd_t d);
    return is_nine(d) ? 4'd0 : bcd_t'(d + 4'd1);
  endfunction

  // Active-high pattern, bit 0 = segment a ... bit 6 = segment g.
  function automatic logic [SEG_W-1:0] seg_pattern(input bcd_t d);
    logic [SEG_W-1:0] p;
    case (d)
      4'd0: p = 7'b0111111;
      4'd1: p = 7'b0000110;
      4'd2: p = 7'b1011011;
      4'd3: p = 7'b1001111;
      4'd4: p = 7'b1100110;
      4'd5: p = 7'b1101101;
      4'd6: p = 7'b1111101;
      4'd7: p = 7'b0000111;
      4'd8: p = 7'b1111111;
      4'd9: p = 7'b1101111;
      default: p = 7'b0000000;
    endcase
    return p;
  endfunction

  // Divider counter width for a divide ratio (at least one bit).
  function automatic int unsigned div_width(input int unsigned div);
    return (div > 1) ? $clog2(div) : 1;
  endfunction

endpackage

// File: rtl/sd_tick_gen.sv
module sd_tick_gen
  import score_disp_pkg::*;
#(
  parameter int unsigned DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic tick
);

  localparam int unsigned CW = div_width(DIV);
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;
  logic          at_last;

  assign at_last = (cnt_q == LAST);
  assign tick    = en && at_last;

  always_ff @(posedge clk) begin
    if (rst)     cnt_q <= '0;
    else if (en) cnt_q <= at_last ? '0 : cnt_q + 1'b1;
  end

  // R2: a paused divider keeps its partial progress
  a_r2_divider_frozen: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(cnt_q));

  // R2: the divider never runs past its last state
  a_r2_divider_bounded: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST);

endmodule

// File: rtl/sd_bcd_counter.sv
module sd_bcd_counter
  import score_disp_pkg::*;
#(
  parameter int unsigned DIGITS = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               inc,
  output bcd_t [DIGITS-1:0]  value,
  output logic               saturated
);

  // carry[i] high when every digit below i holds 9
  logic [DIGITS:0] carry;
  assign carry[0]  = 1'b1;
  assign saturated = carry[DIGITS];

  for (genvar i = 0; i < DIGITS; i++) begin : g_digit
    bcd_t d_q;

    assign carry[i+1] = carry[i] && is_nine(d_q);
    assign value[i]   = d_q;

    always_ff @(posedge clk) begin
      if (rst)                               d_q <= '0;
      else if (inc && !saturated && carry[i]) d_q <= bcd_step(d_q);
    end

    // R3: every digit stays a legal decimal digit
    a_r3_digit_legal: assert property (@(posedge clk) disable iff (rst)
      d_q <= 4'd9);
  end

  // R2: without a tick the count does not move
  a_r2_idle_stable: assert property (@(posedge clk) disable iff (rst)
    !inc |=> $stable(value));

  // R3: the ones digit wraps to zero on a carry
  a_r3_ones_wrap: assert property (@(posedge clk) disable iff (rst)
    (inc && !saturated && is_nine(value[0])) |=> value[0] == 4'd0);

  // R4: once full, the count stays full
  a_r4_hold_at_max: assert property (@(posedge clk) disable iff (rst)
    saturated |=> saturated && $stable(value));

endmodule

// File: rtl/sd_scan_mux.sv
module sd_scan_mux
  import score_disp_pkg::*;
#(
  parameter int unsigned DIGITS = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               step,
  input  bcd_t [DIGITS-1:0]  digits,
  output logic [DIGITS-1:0]  an_n,
  output logic [SEG_W-1:0]   seg_n
);

  localparam int unsigned PW = div_width(DIGITS);
  localparam logic [PW-1:0] LAST_POS = PW'(DIGITS - 1);

  logic [PW-1:0] pos_q;
  bcd_t          shown;

  always_ff @(posedge clk) begin
    if (rst)       pos_q <= '0;
    else if (step) pos_q <= (pos_q == LAST_POS) ? '0 : pos_q + 1'b1;
  end

  assign shown = digits[pos_q];
  assign an_n  = ~(DIGITS'(1) << pos_q);
  assign seg_n = ~seg_pattern(shown);

  // R5: exactly one position driven at a time
  a_r5_one_anode: assert property (@(posedge clk) disable iff (rst)
    $countones(~an_n) == 1);

  // R5: a scan step always moves to another position
  a_r5_step_moves: assert property (@(posedge clk) disable iff (rst)
    step |=> pos_q != $past(pos_q));

  // R5: between steps the position holds
  a_r5_dwell: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(pos_q));

endmodule

// File: rtl/score_timer_display.sv
module score_timer_display
  import score_disp_pkg::*;
#(
  parameter int unsigned CLK_HZ      = 100_000_000,
  parameter int unsigned TICK_DIV    = CLK_HZ,
  parameter int unsigned REFRESH_DIV = CLK_HZ / 1000,
  parameter int unsigned DIGITS      = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              count_en,
  output logic [DIGITS-1:0] an_n,
  output logic [6:0]        seg_n,
  output logic              dp_n
);

  // Named internal events for the assertions
  logic              sec_tick;
  logic              scan_step;
  logic              at_max;
  bcd_t [DIGITS-1:0] count_val;

  sd_tick_gen #(.DIV(TICK_DIV)) u_sec_div (
    .clk  (clk),
    .rst  (rst),
    .en   (count_en),
    .tick (sec_tick)
  );

  sd_tick_gen #(.DIV(REFRESH_DIV)) u_scan_div (
    .clk  (clk),
    .rst  (rst),
    .en   (1'b1),
    .tick (scan_step)
  );

  sd_bcd_counter #(.DIGITS(DIGITS)) u_count (
    .clk       (clk),
    .rst       (rst),
    .inc       (sec_tick),
    .value     (count_val),
    .saturated (at_max)
  );

  sd_scan_mux #(.DIGITS(DIGITS)) u_scan (
    .clk    (clk),
    .rst    (rst),
    .step   (scan_step),
    .digits (count_val),
    .an_n   (an_n),
    .seg_n  (seg_n)
  );

  assign dp_n = 1'b1;

  // R1: reset leaves a zero count and the ones position selected
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (count_val == '0) && (an_n == ~DIGITS'(1)));

  // R2: seconds only tick while the game runs
  a_r2_tick_gated: assert property (@(posedge clk) disable iff (rst)
    sec_tick |-> count_en);

  // R6: decimal point never lit
  a_r6_dp_off: assert property (@(posedge clk) disable iff (rst)
    dp_n == 1'b1);

endmodule

// File: tb/tb_score_timer_display.sv
module tb_score_timer_display;

  localparam int CLK_PERIOD = 10;
  localparam int TICK       = 3;
  localparam int REFRESH    = 4;
  localparam int ND         = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          count_en = 1'b0;
  logic [ND-1:0] an_n;
  logic [6:0]    seg_n;
  logic          dp_n;

  int vectors = 0;
  int misses  = 0;
  bit done    = 1'b0;

  int exp_q[$];
  string tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  score_timer_display #(
    .TICK_DIV(TICK), .REFRESH_DIV(REFRESH), .DIGITS(ND)
  ) dut (
    .clk(clk), .rst(rst), .count_en(count_en),
    .an_n(an_n), .seg_n(seg_n), .dp_n(dp_n)
  );

  // Active-low gfedcba patterns written out directly
  function automatic logic [6:0] want_seg(input int d);
    case (d)
      0: return 7'h40;  1: return 7'h79;  2: return 7'h24;  3: return 7'h30;
      4: return 7'h19;  5: return 7'h12;  6: return 7'h02;  7: return 7'h78;
      8: return 7'h00;  9: return 7'h10;
      default: return 7'h7f;
    endcase
  endfunction

  function automatic int which_pos(input logic [ND-1:0] a);
    for (int k = 0; k < ND; k++)
      if (a == ~(ND'(1) << k)) return k;
    return -1;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      misses++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Driver: run n whole seconds of enabled time, then pause
  task automatic run_secs(input int n);
    count_en = 1'b1;
    repeat (n * TICK) @(negedge clk);
    count_en = 1'b0;
  endtask

  // Driver: queue an expected count and wait for the monitor
  task automatic expect_count(input int v, input string req);
    exp_q.push_back(v);
    tag_q.push_back(req);
    wait (exp_q.size() == 0);
  endtask

  // Monitor: scan the display and compare against the queued value
  initial begin
    forever begin
      logic [6:0] seen [ND];
      bit got [ND];
      int left;
      int v;
      string req;
      wait (exp_q.size() > 0);
      v = exp_q[0];
      req = tag_q[0];
      for (int k = 0; k < ND; k++) got[k] = 1'b0;
      left = ND;
      for (int c = 0; c < 4 * ND * REFRESH && left > 0; c++) begin
        int p;
        @(negedge clk);
        p = which_pos(an_n);
        check(p >= 0, "R5 one anode", int'(an_n), -1);
        check(dp_n == 1'b1, "R6 dp off", int'(dp_n), 1);
        if (p >= 0 && !got[p]) begin
          got[p] = 1'b1;
          seen[p] = seg_n;
          left--;
        end
      end
      for (int k = 0; k < ND; k++) begin
        int d;
        d = (v / (10 ** k)) % 10;
        check(got[k] && seen[k] == want_seg(d), $sformatf("%s R7 digit %0d", req, k),
              int'(seen[k]), int'(want_seg(d)));
      end
      void'(exp_q.pop_front());
      void'(tag_q.pop_front());
    end
  end

  // R5: dwell and ordering of the scan
  task automatic check_scan(input string req);
    int prev;
    int cur;
    int dwell;
    prev = which_pos(an_n);
    while (which_pos(an_n) == prev) @(negedge clk);
    prev = which_pos(an_n);
    for (int s = 0; s < 2 * ND; s++) begin
      dwell = 0;
      while (which_pos(an_n) == prev) begin
        @(negedge clk);
        dwell++;
      end
      cur = which_pos(an_n);
      check(dwell == REFRESH, {req, " R5 dwell"}, dwell, REFRESH);
      check(cur == (prev + 1) % ND, {req, " R5 order"}, cur, (prev + 1) % ND);
      prev = cur;
    end
  endtask

  initial begin
    repeat (2) @(negedge clk);
    rst = 1'b0;
    // R1: reset state straight after release
    check(an_n == 4'b1110, "R1 anode after reset", int'(an_n), 14);
    check(seg_n == 7'h40, "R1 segments after reset", int'(seg_n), 64);
    expect_count(0, "R1");

    check_scan("idle");
    run_secs(7);
    expect_count(7, "R2 seven seconds");
    repeat (20) @(negedge clk);
    expect_count(7, "R2 paused");
    // R2: split enabled time accumulates
    count_en = 1'b1;
    repeat (TICK - 1) @(negedge clk);
    count_en = 1'b0;
    repeat (10) @(negedge clk);
    expect_count(7, "R2 partial");
    count_en = 1'b1;
    @(negedge clk);
    count_en = 1'b0;
    expect_count(8, "R2 completed");
    run_secs(2);
    expect_count(10, "R3 ones carry");
    run_secs(89);
    expect_count(99, "R3 before tens carry");
    run_secs(1);
    expect_count(100, "R3 tens carry");
    count_en = 1'b1;
    check_scan("counting");
    count_en = 1'b0;
    expect_count(100 + (2 * ND * REFRESH + REFRESH) / TICK, "R2 during scan");
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    expect_count(0, "R1 reset mid game");
    run_secs(999);
    expect_count(999, "R3 before hundreds carry");
    run_secs(1);
    expect_count(1000, "R3 hundreds carry");
    run_secs(8999);
    expect_count(9999, "R4 reaches max");
    run_secs(5);
    expect_count(9999, "R4 saturates");
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    expect_count(0, "R1 reset from max");
    run_secs(3);
    expect_count(3, "R2 after reset");
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        vectors++;
        misses++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule